// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches a received line one bit period at a time and keeps a loss-of-signal alarm. Each bit period is marked by a single-cycle strobe. On that strobe the block samples two comparator results that have already been turned into logic levels: "level under the low threshold" and "level over the high threshold". It also samples the recovered data bit. The analog front end is not part of the block, and neither are line decoding or any register access.

A two-bit select picks one of three alarm criteria. The alarm is raised when the level stays under the low threshold for an unbroken run of bit periods. That run is 192 periods long, or 2048 periods in the long-window E1 mode.

How the alarm clears depends on the mode. In the two E1 modes it clears after 192 unbroken bit periods over the high threshold. In the T1/J1 mode the block checks back-to-back 192-period windows, and at the end of each window it looks at three things: the ones density, the longest run of zeros, and a further zero-run limit that applies when zero substitution coding (B8ZS) is on. A one-cycle change pulse goes with every change of the alarm.

Top module: `sig_loss_mon`

## Requirements
- R1: While rstN is low at a clock edge, losOut and losChange go to 0 and every internal count is cleared.
- R2: With critSel = 2'b00 (T1/J1), 2'b01 (E1 short) or 2'b11 (same as 2'b01), losOut rises on the 192nd consecutive bitTick that has lvlLow = 1.
- R3: With critSel = 2'b10 (E1 long), losOut rises on the 2048th consecutive bitTick that has lvlLow = 1.
- R4: While losOut is 0, a bitTick with lvlLow = 0 restarts the count toward R2/R3 from zero.
- R5: In critSel 2'b01, 2'b10 or 2'b11, losOut falls on the 192nd consecutive bitTick with lvlHigh = 1. A bitTick with lvlHigh = 0 restarts that count.
- R6: In critSel 2'b00 with losOut = 1, bitTicks are grouped into non-overlapping windows of 192 ticks. The first window starts at the first tick after losOut rises. A tick counts as a one when lvlHigh = 1 and dataOne = 1. losOut falls on the last tick of a window only if that window held at least 24 ones. If it did not, a fresh window begins.
- R7: In critSel 2'b00, a window that contains a run of 100 or more consecutive non-one ticks does not clear losOut. A run of 99 does not block clearing.
- R8: In critSel 2'b00 with b8zsEn = 1, a window that contains a run of 8 consecutive non-one ticks does not clear losOut. With b8zsEn = 0, such a run does not block clearing.
- R9: losChange is 1 for exactly the one cycle in which losOut first shows a new value, and is 0 at all other times.
- R10: On a clock edge where critSel differs from its value in the previous cycle, all counts are cleared and any bitTick in that cycle is ignored. losOut keeps its value and no losChange pulse is produced.
- R11: losOut never changes on a cycle where bitTick is 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bitTick | input | 1 | One-cycle strobe per received bit period |
| lvlLow | input | 1 | Line level is below the low threshold |
| lvlHigh | input | 1 | Line level is above the high threshold |
| dataOne | input | 1 | Recovered data bit is a one |
| b8zsEn | input | 1 | Zero-substitution coding is in use (T1/J1 mode) |
| critSel | input | 2 | Criteria select: 00 T1/J1, 01 E1 short, 10 E1 long, 11 as 01 |
| losOut | output | 1 | Loss-of-signal alarm |
| losChange | output | 1 | One-cycle pulse on each alarm change |

## Verification
In every mode, runs of low-level ticks are stopped one tick short of the window and then completed. This separates a correct window length from an off-by-one, and an unbroken run from a run that was interrupted. In the T1/J1 mode, whole windows are played with exactly 23 or 24 ones, with a zero run of 99 or 100, and with a run of 8 zeros under both settings of b8zsEn. Each of these pairs differs in a single count, so each one isolates a single clearing condition and the window-boundary reset. Mode changes made partway through a count, and long stretches of qualifying levels with no strobe, show that counts are cleared on a mode change and advance only on the strobe.

// File: rtl/sig_loss_pkg.sv
package sig_loss_pkg;

  localparam logic [1:0] SEL_T1  = 2'b00;
  localparam logic [1:0] SEL_E1L = 2'b10;

  // control -> datapath strobes
  typedef struct packed {
    logic clrAll;
    logic runAdv;
    logic runRst;
    logic winAdv;
    logic winRst;
    logic longWin;
  } dpCmd_t;

  // datapath -> control flags
  typedef struct packed {
    logic runLast;
    logic winLast;
    logic winPass;
  } dpStat_t;

endpackage

// File: rtl/sig_loss_dp.sv
module sig_loss_dp
  import sig_loss_pkg::*;
#(
  parameter int SHORT_WIN  = 192,
  parameter int LONG_WIN   = 2048,
  parameter int ONES_MIN   = 24,
  parameter int ZERO_LIMIT = 100,
  parameter int SUB_RUN    = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitOne,
  input  logic    b8zsEn,
  input  dpCmd_t  cmd,
  output dpStat_t stat
);

  localparam int RUN_W = $clog2(LONG_WIN + 1);
  localparam int WIN_W = $clog2(SHORT_WIN + 1);
  localparam int ONE_W = $clog2(ONES_MIN + 1);
  localparam int ZR_W  = $clog2(ZERO_LIMIT + 1);

  logic [RUN_W-1:0] runCnt;
  logic [WIN_W-1:0] winCnt;
  logic [ONE_W-1:0] onesCnt, onesNx;
  logic [ZR_W-1:0]  zeroRun, zeroRunNx;
  logic             failQ, failNx;

  // next-state of window trackers including the current bit
  always_comb begin
    if (bitOne)
      zeroRunNx = '0;
    else if (zeroRun == ZR_W'(ZERO_LIMIT))
      zeroRunNx = zeroRun;
    else
      zeroRunNx = zeroRun + 1'b1;

    if (bitOne && onesCnt != ONE_W'(ONES_MIN))
      onesNx = onesCnt + 1'b1;
    else
      onesNx = onesCnt;

    failNx = failQ
           | (zeroRunNx == ZR_W'(ZERO_LIMIT))
           | (b8zsEn && (zeroRunNx >= ZR_W'(SUB_RUN)));
  end

  assign stat.runLast = cmd.longWin ? (runCnt == RUN_W'(LONG_WIN - 1))
                                    : (runCnt == RUN_W'(SHORT_WIN - 1));
  assign stat.winLast = (winCnt == WIN_W'(SHORT_WIN - 1));
  assign stat.winPass = (onesNx == ONE_W'(ONES_MIN)) && !failNx;

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrAll) begin
      runCnt  <= '0;
      winCnt  <= '0;
      onesCnt <= '0;
      zeroRun <= '0;
      failQ   <= 1'b0;
    end else begin
      if (cmd.runRst)
        runCnt <= '0;
      else if (cmd.runAdv)
        runCnt <= runCnt + 1'b1;

      if (cmd.winRst) begin
        winCnt  <= '0;
        onesCnt <= '0;
        zeroRun <= '0;
        failQ   <= 1'b0;
      end else if (cmd.winAdv) begin
        winCnt  <= winCnt + 1'b1;
        onesCnt <= onesNx;
        zeroRun <= zeroRunNx;
        failQ   <= failNx;
      end
    end
  end

endmodule

// File: rtl/sig_loss_ctl.sv
module sig_loss_ctl
  import sig_loss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       lvlLow,
  input  logic       lvlHigh,
  input  logic [1:0] critSel,
  input  dpStat_t    stat,
  output dpCmd_t     cmd,
  output logic       losQ,
  output logic       chgQ
);

  logic [1:0] selQ;
  logic       modeChg, isT1, setLos, clrLos;

  assign modeChg = (critSel != selQ);
  assign isT1    = (critSel == SEL_T1);

  always_comb begin
    cmd         = '0;
    setLos      = 1'b0;
    clrLos      = 1'b0;
    cmd.longWin = (critSel == SEL_E1L) && !losQ;
    if (modeChg) begin
      cmd.clrAll = 1'b1;
    end else if (bitTick) begin
      if (!losQ) begin
        if (lvlLow) begin
          if (stat.runLast) begin
            setLos     = 1'b1;
            cmd.runRst = 1'b1;
          end else begin
            cmd.runAdv = 1'b1;
          end
        end else begin
          cmd.runRst = 1'b1;
        end
      end else if (isT1) begin
        if (stat.winLast) begin
          cmd.winRst = 1'b1;
          clrLos     = stat.winPass;
        end else begin
          cmd.winAdv = 1'b1;
        end
      end else begin
        if (lvlHigh) begin
          if (stat.runLast) begin
            clrLos     = 1'b1;
            cmd.runRst = 1'b1;
          end else begin
            cmd.runAdv = 1'b1;
          end
        end else begin
          cmd.runRst = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      losQ <= 1'b0;
      chgQ <= 1'b0;
      selQ <= SEL_T1;
    end else begin
      if (setLos)
        losQ <= 1'b1;
      else if (clrLos)
        losQ <= 1'b0;
      chgQ <= setLos | clrLos;
      selQ <= critSel;
    end
  end

endmodule

// File: rtl/sig_loss_mon.sv
module sig_loss_mon
  import sig_loss_pkg::*;
#(
  parameter int SHORT_WIN  = 192,
  parameter int LONG_WIN   = 2048,
  parameter int ONES_MIN   = 24,
  parameter int ZERO_LIMIT = 100,
  parameter int SUB_RUN    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       lvlLow,
  input  logic       lvlHigh,
  input  logic       dataOne,
  input  logic       b8zsEn,
  input  logic [1:0] critSel,
  output logic       losOut,
  output logic       losChange
);

  dpCmd_t  cmd;
  dpStat_t stat;

  sig_loss_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .bitTick (bitTick),
    .lvlLow  (lvlLow),
    .lvlHigh (lvlHigh),
    .critSel (critSel),
    .stat    (stat),
    .cmd     (cmd),
    .losQ    (losOut),
    .chgQ    (losChange)
  );

  sig_loss_dp #(
    .SHORT_WIN  (SHORT_WIN),
    .LONG_WIN   (LONG_WIN),
    .ONES_MIN   (ONES_MIN),
    .ZERO_LIMIT (ZERO_LIMIT),
    .SUB_RUN    (SUB_RUN)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .bitOne (lvlHigh & dataOne),
    .b8zsEn (b8zsEn),
    .cmd    (cmd),
    .stat   (stat)
  );

endmodule

// File: rtl/sig_loss_chk.sv
module sig_loss_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bitTick,
  input logic       lvlLow,
  input logic       lvlHigh,
  input logic [1:0] critSel,
  input logic       losOut,
  input logic       losChange
);

  a_r9_pulse_on_change: assert property (@(posedge clk) disable iff (!rstN)
    (losOut != $past(losOut)) |-> losChange);

  a_r9_pulse_only_on_change: assert property (@(posedge clk) disable iff (!rstN)
    losChange |-> (losOut != $past(losOut)));

  a_r11_change_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    losChange |-> $past(bitTick));

  a_r2_set_needs_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(losOut) |-> $past(lvlLow));

  a_r5_e1_clear_needs_high: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(losOut) && ($past(critSel) != 2'b00)) |-> $past(lvlHigh));

  a_r10_mode_change_holds: assert property (@(posedge clk) disable iff (!rstN)
    (critSel != $past(critSel)) |=> $stable(losOut));

endmodule

bind sig_loss_mon sig_loss_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitTick   (bitTick),
  .lvlLow    (lvlLow),
  .lvlHigh   (lvlHigh),
  .critSel   (critSel),
  .losOut    (losOut),
  .losChange (losChange)
);

// File: tb/sim_sig_loss_mon.sv
module sim_sig_loss_mon;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic       lvlLow = 1'b0;
  logic       lvlHigh = 1'b0;
  logic       dataOne = 1'b0;
  logic       b8zsEn = 1'b0;
  logic [1:0] critSel = 2'b00;
  logic       losOut, losChange;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  sig_loss_mon u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .lvlLow(lvlLow),
    .lvlHigh(lvlHigh), .dataOne(dataOne), .b8zsEn(b8zsEn),
    .critSel(critSel), .losOut(losOut), .losChange(losChange)
  );

  // entry: {mode[1:0], ticks[11:0], low, high, one, expLos}
  localparam int NVEC = 15;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd1, 12'd191,  1'b1, 1'b0, 1'b0, 1'b0},  // R2 one short
    {2'd1, 12'd1,    1'b1, 1'b0, 1'b0, 1'b1},  // R2 192nd
    {2'd1, 12'd191,  1'b0, 1'b1, 1'b0, 1'b1},  // R5 one short
    {2'd1, 12'd1,    1'b0, 1'b0, 1'b0, 1'b1},  // R5 break
    {2'd1, 12'd192,  1'b0, 1'b1, 1'b0, 1'b0},  // R5 clear
    {2'd2, 12'd2047, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 one short
    {2'd2, 12'd1,    1'b1, 1'b0, 1'b0, 1'b1},  // R3 2048th
    {2'd2, 12'd192,  1'b0, 1'b1, 1'b0, 1'b0},  // R5 long mode clear
    {2'd3, 12'd192,  1'b1, 1'b0, 1'b0, 1'b1},  // R2 mode 11
    {2'd3, 12'd100,  1'b0, 1'b1, 1'b0, 1'b1},  // R5 partial
    {2'd3, 12'd92,   1'b0, 1'b1, 1'b0, 1'b0},  // R5 clear
    {2'd0, 12'd100,  1'b1, 1'b0, 1'b0, 1'b0},  // R4 partial
    {2'd0, 12'd1,    1'b0, 1'b0, 1'b0, 1'b0},  // R4 break
    {2'd0, 12'd191,  1'b1, 1'b0, 1'b0, 1'b0},  // R4 restart short
    {2'd0, 12'd1,    1'b1, 1'b0, 1'b0, 1'b1}   // R4 restart done
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doTick(input logic l, input logic h, input logic o);
    @(negedge clk);
    bitTick = 1'b1; lvlLow = l; lvlHigh = h; dataOne = o;
    @(negedge clk);
    bitTick = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk);
    critSel = m;
    @(negedge clk);
  endtask

  function automatic logic patBit(input int kind, input int head, input int i);
    case (kind)
      0:       return (i % 8) == 7;
      1:       return ((i % 8) == 7) && (i < 184);
      default: return i >= head;
    endcase
  endfunction

  task automatic t1Bits(input int kind, input int head, input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      logic b;
      b = patBit(kind, head, i);
      doTick(1'b0, b, b);
    end
  endtask

  task automatic lowRun(input int n);
    for (int i = 0; i < n; i++) doTick(1'b1, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 reset losOut", losOut, 1'b0);
    chk("R1 reset losChange", losChange, 1'b0);
    rstN = 1'b1;

    // vector table walk
    for (int k = 0; k < NVEC; k++) begin
      logic [17:0] v;
      v = VEC[k];
      if (v[17:16] != critSel) setMode(v[17:16]);
      for (int t = 0; t < int'(v[15:4]); t++) doTick(v[3], v[2], v[1]);
      chk($sformatf("R2-group vector %0d", k), losOut, v[0]);
    end

    // now mode 00, LOS = 1, fresh window
    // R6: 23 ones does not clear; next window with 24 ones clears
    t1Bits(1, 0, 0, 192);
    chk("R6 23 ones keeps LOS", losOut, 1'b1);
    t1Bits(0, 0, 0, 191);
    chk("R6 window not done", losOut, 1'b1);
    t1Bits(0, 0, 191, 192);
    chk("R6 24 ones clears", losOut, 1'b0);
    chk("R9 pulse on clear", losChange, 1'b1);
    @(negedge clk);
    chk("R9 pulse one cycle", losChange, 1'b0);

    lowRun(192);
    chk("R2 T1 set", losOut, 1'b1);
    chk("R9 pulse on set", losChange, 1'b1);
    @(negedge clk);
    chk("R9 pulse gone", losChange, 1'b0);

    // R7 zero runs
    t1Bits(2, 100, 0, 192);
    chk("R7 run of 100 blocks", losOut, 1'b1);
    t1Bits(2, 99, 0, 192);
    chk("R7 run of 99 clears", losOut, 1'b0);

    // R8 with b8zs on
    b8zsEn = 1'b1;
    lowRun(192);
    chk("R8 set", losOut, 1'b1);
    t1Bits(2, 8, 0, 192);
    chk("R8 run of 8 blocks with b8zs", losOut, 1'b1);
    t1Bits(0, 0, 0, 192);
    chk("R8 runs of 7 clear with b8zs", losOut, 1'b0);
    b8zsEn = 1'b0;
    lowRun(192);
    t1Bits(2, 8, 0, 192);
    chk("R8 run of 8 clears without b8zs", losOut, 1'b0);

    // R11: levels without strobe do nothing
    @(negedge clk);
    lvlLow = 1'b1;
    repeat (400) @(negedge clk);
    chk("R11 no tick no set", losOut, 1'b0);
    lvlLow = 1'b0;

    // R10: mode change clears partial count
    lowRun(100);
    setMode(2'd1);
    lowRun(100);
    chk("R10 count cleared by mode change", losOut, 1'b0);
    lowRun(92);
    chk("R10 full count after change", losOut, 1'b1);
    setMode(2'd2);
    chk("R10 LOS kept on mode change", losOut, 1'b1);
    chk("R10 no pulse on mode change", losChange, 1'b0);
    for (int i = 0; i < 192; i++) doTick(1'b0, 1'b1, 1'b0);
    chk("R5 long mode clears after 192 high", losOut, 1'b0);

    // R1: reset while alarmed
    setMode(2'd1);
    lowRun(192);
    chk("R1 alarmed before reset", losOut, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset clears LOS", losOut, 1'b0);
    chk("R1 reset clears pulse", losChange, 1'b0);
    rstN = 1'b1;
    lowRun(191);
    chk("R1 counts cleared by reset", losOut, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule